// File: doc/BRIEF.md
# One-Shot Diagnostic Interrupt Pulse Generator

This block drives the platform's diagnostic interrupt (NMI) line. Three synchronous, single-cycle request inputs can ask for a pulse: a front-panel button press that has already been debounced, a watchdog pre-timeout whose configured action is the diagnostic interrupt, and a host chassis-control command. When a request is accepted, the block raises its interrupt output for a fixed number of clock cycles. That number is a parameter and must be chosen to span at least 30 ms at the system clock rate. The default assumes a 50 MHz clock.

Once a pulse has been issued, the block latches a lockout. While the lockout is set, every further request is discarded, and none is held back for later. The lockout stays set until the system clear input, which represents a system reset or a power-down, is asserted. The clear input also ends any pulse that is still in progress.

In the first cycle of each pulse the block can emit a one-cycle event-log strobe together with a 2-bit cause code. Causes from the button and from the watchdog are logged. A pulse requested by the chassis-control command is never logged. When several requests arrive in the same cycle, one cause is selected by fixed priority.

Top module: `diag_nmi_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `nmi_o`, `log_stb_o` and `log_cause_o` are all 0, and the lockout is clear, so the first request after reset is accepted.
- R2: A request sampled at a clock edge while the lockout is clear makes `nmi_o` high from that edge onward for exactly `PULSE_CYCLES` consecutive cycles, provided `sys_clr_i` stays low.
- R3: After a pulse has started, requests from any source produce no new pulse, no strobe and no extension of the current pulse, until `sys_clr_i` is asserted.
- R4: A pulse caused only by the chassis-control request (`req_host_i`) leaves `log_stb_o` low for the whole pulse.
- R5: A pulse caused by `req_button_i` or `req_wdog_i` raises `log_stb_o` for exactly one cycle, which is the first cycle of the pulse. In that cycle `log_cause_o` reads 2'b01 for the button or 2'b10 for the watchdog.
- R6: Requests that arrive together are resolved by fixed priority: button first, then watchdog, then chassis command. Only one pulse and one cause code result.
- R7: `sys_clr_i` sampled high forces `nmi_o` low from the next cycle and clears the lockout. A request one cycle after the clear is accepted.
- R8: A request sampled in the same cycle as `sys_clr_i` is dropped and produces no pulse.
- R9: `log_cause_o` is 2'b00 in every cycle in which `log_stb_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_clr_i | input | 1 | Synchronous clear standing for system reset or power-down; clears the lockout and ends any pulse |
| req_host_i | input | 1 | Single-cycle chassis-control pulse request (never logged) |
| req_button_i | input | 1 | Single-cycle debounced front-panel button request |
| req_wdog_i | input | 1 | Single-cycle watchdog pre-timeout request with interrupt action enabled |
| nmi_o | output | 1 | Diagnostic interrupt pulse, active high |
| log_stb_o | output | 1 | One-cycle event-log strobe |
| log_cause_o | output | 2 | Cause code sent with the strobe: 01 button, 10 watchdog |

## Verification
A lockout flag stuck low shows up at the ports as a second rise of `nmi_o` after the first pulse completes. A lockout flag stuck high means no pulse ever appears after a clear. Either fault is visible within one cycle of the next request. A counter that is off by one changes the pulse length, which the bench detects at the falling edge of the pulse, `PULSE_CYCLES` cycles after it starts. Faults in the priority or in the logging rule appear as a wrong cause code, or a missing or extra strobe, in the first cycle of the pulse.

// File: rtl/diag_nmi_pkg.sv
package diag_nmi_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_BUTTON = 2'b01,
        CAUSE_WDOG   = 2'b10,
        CAUSE_HOST   = 2'b11
    } nmi_cause_e;

    typedef struct packed {
        logic button;
        logic wdog;
        logic host;
    } nmi_req_t;

    typedef struct packed {
        logic       valid;
        nmi_cause_e cause;
        logic       logged;
    } nmi_grant_t;

    function automatic nmi_cause_e pick_cause(input nmi_req_t r);
        if (r.button)    return CAUSE_BUTTON;
        else if (r.wdog) return CAUSE_WDOG;
        else if (r.host) return CAUSE_HOST;
        else             return CAUSE_NONE;
    endfunction

    function automatic logic cause_is_logged(input nmi_cause_e c);
        return (c == CAUSE_BUTTON) || (c == CAUSE_WDOG);
    endfunction

endpackage

// File: rtl/diag_req_arbiter.sv
module diag_req_arbiter
    import diag_nmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  nmi_req_t   req,
    output nmi_grant_t grant
);

    always_comb begin
        grant.cause  = pick_cause(req);
        grant.valid  = (grant.cause != CAUSE_NONE);
        grant.logged = cause_is_logged(grant.cause);
    end

    // R6: a button request always wins the cause selection
    assert_button_first_R6: assert property (@(posedge clk) disable iff (rst)
        req.button |-> (grant.cause == CAUSE_BUTTON));

    // R4: the host command is never marked for logging
    assert_host_unlogged_R4: assert property (@(posedge clk) disable iff (rst)
        (req == 3'b001) |-> !grant.logged);

endmodule

// File: rtl/diag_lockout.sv
module diag_lockout (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic locked_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            locked_o <= 1'b0;
        end else if (set_i) begin
            locked_o <= 1'b1;
        end
    end

    // R7: a clear always removes the lock one cycle later
    assert_clear_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !locked_o);

    // R3: once set, the lock persists until a clear arrives
    assert_lock_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !clr_i) |=> locked_o);

endmodule

// File: rtl/diag_pulse_timer.sv
module diag_pulse_timer #(
    parameter int unsigned PULSE_CYCLES = 1_500_000,
    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    output logic active_o
);

    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            active_o <= 1'b0;
            remain_q <= '0;
        end else if (start_i && !active_o) begin
            active_o <= 1'b1;
            remain_q <= LOAD;
        end else if (active_o) begin
            if (remain_q == '0) begin
                active_o <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // R2: the remaining count never exceeds the loaded value
    assert_remain_bound_R2: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (remain_q <= LOAD));

endmodule

// File: rtl/diag_nmi_gen.sv
module diag_nmi_gen
    import diag_nmi_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 1_500_000,
    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_clr_i,
    input  logic       req_host_i,
    input  logic       req_button_i,
    input  logic       req_wdog_i,
    output logic       nmi_o,
    output logic       log_stb_o,
    output logic [1:0] log_cause_o
);

    nmi_req_t   req;
    nmi_grant_t grant;
    logic       locked;
    logic       accept;

    assign req.button = req_button_i;
    assign req.wdog   = req_wdog_i;
    assign req.host   = req_host_i;

    diag_req_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .grant (grant)
    );

    assign accept = grant.valid && !locked && !sys_clr_i;

    diag_lockout u_lock (
        .clk      (clk),
        .rst      (rst),
        .set_i    (accept),
        .clr_i    (sys_clr_i),
        .locked_o (locked)
    );

    diag_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (accept),
        .stop_i   (sys_clr_i),
        .active_o (nmi_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            log_stb_o   <= 1'b0;
            log_cause_o <= CAUSE_NONE;
        end else if (accept && grant.logged) begin
            log_stb_o   <= 1'b1;
            log_cause_o <= grant.cause;
        end else begin
            log_stb_o   <= 1'b0;
            log_cause_o <= CAUSE_NONE;
        end
    end

    // assertion support: number of high cycles already seen in the current pulse
    logic [CW-1:0] hi_seen;
    always_ff @(posedge clk) begin
        if (rst || !nmi_o) hi_seen <= '0;
        else               hi_seen <= hi_seen + 1'b1;
    end

    // R2: the pulse is never longer than PULSE_CYCLES
    assert_width_max_R2: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> (hi_seen < CW'(PULSE_CYCLES)));

    // R2: a pulse that is not cut short by a clear lasts exactly PULSE_CYCLES
    assert_width_exact_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(nmi_o) && !$past(sys_clr_i)) |-> ($past(hi_seen) == CW'(PULSE_CYCLES - 1)));

    // R3: a pulse can only begin while the lockout was clear
    assert_start_unlocked_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_o) |-> $past(!locked));

    // R5: the strobe marks only the first cycle of a pulse
    assert_stb_first_R5: assert property (@(posedge clk) disable iff (rst)
        log_stb_o |-> $rose(nmi_o));

    // R9: the cause code is zero outside strobe cycles
    assert_cause_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !log_stb_o |-> (log_cause_o == 2'b00));

    // R4: the host cause code never reaches the log port
    assert_no_host_log_R4: assert property (@(posedge clk) disable iff (rst)
        log_stb_o |-> (log_cause_o == 2'b01 || log_cause_o == 2'b10));

    // R7: a clear ends the pulse on the next cycle
    assert_clear_stops_R7: assert property (@(posedge clk) disable iff (rst)
        sys_clr_i |=> !nmi_o);

endmodule

// File: tb/test_diag_nmi_gen.sv
module test_diag_nmi_gen;

    localparam int unsigned N = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_clr_i = 1'b0;
    logic       req_host_i = 1'b0;
    logic       req_button_i = 1'b0;
    logic       req_wdog_i = 1'b0;
    logic       nmi_o;
    logic       log_stb_o;
    logic [1:0] log_cause_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit       m_nmi = 0;
    bit       m_lock = 0;
    int       m_rem = 0;
    bit       m_stb = 0;
    bit [1:0] m_cause = 2'b00;

    always #10 clk = ~clk;

    diag_nmi_gen #(.PULSE_CYCLES(N)) i_diag_nmi_gen (
        .clk          (clk),
        .rst          (rst),
        .sys_clr_i    (sys_clr_i),
        .req_host_i   (req_host_i),
        .req_button_i (req_button_i),
        .req_wdog_i   (req_wdog_i),
        .nmi_o        (nmi_o),
        .log_stb_o    (log_stb_o),
        .log_cause_o  (log_cause_o)
    );

    function automatic bit [1:0] exp_cause(bit b, bit w, bit h);
        if (b) return 2'b01;
        if (w) return 2'b10;
        if (h) return 2'b11;
        return 2'b00;
    endfunction

    function automatic bit exp_logged(bit [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // drive one cycle of inputs, advance the model, compare after the edge
    task automatic step(bit b, bit w, bit h, bit c, string tag);
        bit [1:0] cz;
        @(negedge clk);
        req_button_i = b;
        req_wdog_i   = w;
        req_host_i   = h;
        sys_clr_i    = c;
        cz = exp_cause(b, w, h);
        @(posedge clk);
        if (c) begin
            m_nmi = 0; m_lock = 0; m_rem = 0; m_stb = 0; m_cause = 2'b00;
        end else if (cz != 2'b00 && !m_lock) begin
            m_nmi = 1; m_lock = 1; m_rem = N;
            m_stb = exp_logged(cz);
            m_cause = m_stb ? cz : 2'b00;
        end else begin
            m_stb = 0; m_cause = 2'b00;
            if (m_nmi) begin
                m_rem--;
                if (m_rem == 0) m_nmi = 0;
            end
        end
        #5;
        check(tag, "nmi_o", nmi_o, m_nmi);
        check(tag, "log_stb_o", log_stb_o, m_stb);
        check(tag, "log_cause_o", log_cause_o, m_cause);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int hi;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #5;
        // R1: outputs idle during reset
        check("R1", "nmi_o in reset", nmi_o, 0);
        check("R1", "log_stb_o in reset", log_stb_o, 0);
        check("R1", "log_cause_o in reset", log_cause_o, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R1");

        // R5 / R2: button pulse logged with code 01, exact width
        step(1, 0, 0, 0, "R5");
        check("R5", "button strobe", log_stb_o, 1);
        check("R5", "button cause", log_cause_o, 2'b01);
        hi = 1;
        for (int i = 0; i < N + 3; i++) begin
            step(0, 0, 0, 0, "R2");
            if (nmi_o) hi++;
        end
        check("R2", "pulse width", hi, N);

        // R3: requests after the pulse are ignored
        step(1, 1, 1, 0, "R3");
        check("R3", "locked nmi_o", nmi_o, 0);
        check("R3", "locked strobe", log_stb_o, 0);
        idle(3, "R3");

        // R7 / R4: clear, then a host command pulses without logging
        step(0, 0, 0, 1, "R7");
        step(0, 0, 1, 0, "R4");
        check("R4", "host nmi_o", nmi_o, 1);
        check("R4", "host strobe", log_stb_o, 0);
        // R3: requests during the active pulse do not extend it
        step(1, 0, 0, 0, "R3");
        check("R3", "in-pulse strobe", log_stb_o, 0);
        idle(N + 2, "R3");

        // R6: all three at once yields the button code
        step(0, 0, 0, 1, "R7");
        step(1, 1, 1, 0, "R6");
        check("R6", "all-three cause", log_cause_o, 2'b01);
        idle(N + 1, "R6");

        // R6: watchdog beats host
        step(0, 0, 0, 1, "R7");
        step(0, 1, 1, 0, "R6");
        check("R6", "wdog-over-host cause", log_cause_o, 2'b10);

        // R7: clear mid-pulse stops it, a request right after is accepted
        idle(3, "R7");
        step(0, 0, 0, 1, "R7");
        check("R7", "cleared nmi_o", nmi_o, 0);
        step(0, 1, 0, 0, "R7");
        check("R7", "post-clear nmi_o", nmi_o, 1);
        check("R5", "wdog cause", log_cause_o, 2'b10);
        idle(N + 1, "R2");

        // R8: request together with clear is dropped
        step(0, 0, 0, 1, "R8");
        step(1, 0, 0, 1, "R8");
        check("R8", "dropped nmi_o", nmi_o, 0);
        idle(2, "R8");
        check("R8", "still idle nmi_o", nmi_o, 0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 16) == 0, ($urandom % 16) == 0,
                 ($urandom % 12) == 0, ($urandom % 40) == 0, "R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule